// File: doc/BRIEF.md
# MII Management Register Front-End

This block turns a pair of software-visible registers into clause-22 management frames on the MDC/MDIO pair of an Ethernet PHY. Software stages a 16-bit value in the data register, then writes a control word carrying a PHY address, a register address and an operation request. The request bit stays set while the frame is on the wire and drops by itself once the frame is done. For a read, the data register then holds what the PHY returned.

MDC is derived from the system clock through an even divider and rests low between frames. MDIO is driven through an output value and an output enable, so the pad can be released while the PHY answers. The line is assumed to be pulled up, so an address with no PHY behind it reads back as all ones.

Top module: `mii_mgmt_regs`

## Requirements
- R1: In the control word, bit 0 requests a read, bit 1 requests a write, bits 13:9 are the PHY address and bits 8:4 the register address. These fields appear MSB first as frame bits 36..40 (PHY) and 41..45 (register).
- R2: Every frame begins with 32 ones and the start code 01. The opcode follows: 10 for a read, 01 for a write. All fields are sent MSB first.
- R3: A write frame carries turnaround 10 and then the 16-bit data register value as it stood when the command was written, MSB first in bits 48..63.
- R4: The requested operation bit reads back as 1 from the cycle after the command write. It clears after exactly 64*CLK_DIV clock cycles, when the frame ends.
- R5: When a read completes, the data register holds the 16 bits the PHY drove during bits 48..63, sampled on rising MDC.
- R6: A read of an address where no PHY drives the line returns 16'hFFFF.
- R7: During a read, mdio_oe_o is high for bits 0..45 and low from the first turnaround bit (46) to the end. During a write it is high for all 64 bits.
- R8: MDC has a period of CLK_DIV system clocks. It shows exactly 64 rising edges per frame and is low whenever no frame runs. MDIO changes only while MDC is low.
- R9: A control write while a frame is in progress is ignored. The control readback is unchanged and no extra frame follows.
- R10: A control word with both operation bits set runs a read.
- R11: A control write with neither operation bit set updates the readback but starts no frame. Reserved bits 15:14 and 3:2 are stored as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 selects the control word, 1 the data register |
| reg_wdata_i | input | 16 | Register write value |
| ctrl_o | output | 16 | Control word readback, including the live operation bits |
| data_o | output | 16 | Data register readback |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line level |

## Verification
A wrong bit counter or shift register shows up within one frame. The recorded line pattern differs from the expected 64-bit frame, and the busy time is not exactly 64*CLK_DIV cycles. A wrong divider state appears at the second MDC rise as a bad period, or as MDC left high after the frame. If the turnaround logic is wrong, the pad is enabled during bit 46 of a read, or the data register is loaded off by one bit. Command filtering errors show as changed readback or a stray frame right after the busy window.

// File: rtl/mii_mgmt_pkg.sv
package mii_mgmt_pkg;
  localparam int FRAME_BITS = 64;
  localparam int CNT_W      = 6;
  localparam int RD_BIT     = 0;
  localparam int WR_BIT     = 1;
  localparam int REG_LSB    = 4;
  localparam int PHY_LSB    = 9;
  localparam int TA_IDX     = 46;
  localparam int DATA_IDX   = 48;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10
  } mdio_op_e;

  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic rd, input logic [4:0] phy, input logic [4:0] rga,
    input logic [15:0] wdata);
    mdio_op_e op;
    op = rd ? OP_READ : OP_WRITE;
    return {32'hFFFF_FFFF, 2'b01, op, phy, rga, 2'b10, wdata};
  endfunction
endpackage

// File: rtl/mdc_gen.sv
module mdc_gen #(
  parameter int CLK_DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          wrap;

  assign wrap   = en_i && (cnt_q == CW'(HALF - 1));
  assign rise_o = wrap && !mdc_q;
  assign fall_o = wrap && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R8
  mdc_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !mdc_o);
endmodule

// File: rtl/mii_frame_eng.sv
module mii_frame_eng
  import mii_mgmt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        rd_i,
  input  logic [4:0]  phy_i,
  input  logic [4:0]  reg_i,
  input  logic [15:0] wdata_i,
  input  logic        rise_i,
  input  logic        fall_i,
  input  logic        mdio_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] rdata_o,
  output logic        mdio_o,
  output logic        mdio_oe_o
);
  logic                  busy_q;
  logic                  rd_q;
  logic [CNT_W-1:0]      bit_q;
  logic [FRAME_BITS-1:0] sh_q;
  logic [15:0]           rsh_q;
  logic                  last_bit;
  logic                  released;

  assign last_bit  = (bit_q == CNT_W'(FRAME_BITS - 1));
  assign released  = rd_q && (bit_q >= CNT_W'(TA_IDX));
  assign busy_o    = busy_q;
  assign done_o    = busy_q && fall_i && last_bit;
  assign rdata_o   = rsh_q;
  assign mdio_o    = busy_q ? sh_q[FRAME_BITS-1] : 1'b1;
  assign mdio_oe_o = busy_q && !released;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      bit_q  <= '0;
      sh_q   <= '0;
      rsh_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        rd_q   <= rd_i;
        bit_q  <= '0;
        sh_q   <= build_frame(rd_i, phy_i, reg_i, wdata_i);
      end
    end else begin
      if (rise_i && rd_q && bit_q >= CNT_W'(DATA_IDX))
        rsh_q <= {rsh_q[14:0], mdio_i};
      if (fall_i) begin
        if (last_bit) begin
          busy_q <= 1'b0;
        end else begin
          bit_q <= bit_q + 1'b1;
          sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/mii_mgmt_regs.sv
module mii_mgmt_regs
  import mii_mgmt_pkg::*;
#(
  parameter int CLK_DIV = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic        reg_sel_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] ctrl_o,
  output logic [15:0] data_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic [15:0] ctrl_q, data_q, rdata;
  logic        busy, done, rise, fall, mdc;
  logic        ctrl_wr, start, want_rd, want_wr;

  assign want_rd = reg_wdata_i[RD_BIT];
  assign want_wr = reg_wdata_i[WR_BIT];
  assign ctrl_wr = reg_we_i && !reg_sel_i && !busy;
  assign start   = ctrl_wr && (want_rd || want_wr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      data_q <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q <= reg_wdata_i;
        // both bits set: read wins
        if (want_rd) ctrl_q[WR_BIT] <= 1'b0;
      end else if (done) begin
        ctrl_q[RD_BIT] <= 1'b0;
        ctrl_q[WR_BIT] <= 1'b0;
      end
      if (done && ctrl_q[RD_BIT])
        data_q <= rdata;
      else if (reg_we_i && reg_sel_i)
        data_q <= reg_wdata_i;
    end
  end

  mdc_gen #(.CLK_DIV(CLK_DIV)) u_mdc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (busy),
    .mdc_o  (mdc),
    .rise_o (rise),
    .fall_o (fall)
  );

  mii_frame_eng u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .rd_i      (want_rd),
    .phy_i     (reg_wdata_i[PHY_LSB +: 5]),
    .reg_i     (reg_wdata_i[REG_LSB +: 5]),
    .wdata_i   (data_q),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .busy_o    (busy),
    .done_o    (done),
    .rdata_o   (rdata),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o)
  );

  assign ctrl_o = ctrl_q;
  assign data_o = data_q;
  assign mdc_o  = mdc;

  // R4
  op_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (ctrl_q[RD_BIT] ^ ctrl_q[WR_BIT]));
  // R9
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !done) |=> $stable(ctrl_q));
  // R8
  mdio_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdc |-> ($stable(mdio_o) && $stable(mdio_oe_o)));
  // R8
  mdc_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mdc);
endmodule

// File: tb/sim_mii_mgmt_regs.sv
`timescale 1ns/1ps
module sim_mii_mgmt_regs;
  localparam int DIV = 8;
  localparam logic [4:0] PHY_ADDR = 5'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, sel = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] ctrl, data;
  logic        mdc, mdo, moe, line;
  logic        drv_en = 1'b0, drv = 1'b1;

  int total = 0, bad = 0;
  int rise_cnt = 0;
  int cyc = 0, last_rise = 0, period = 0;
  logic [63:0] seen, oe_seen;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign line = moe ? mdo : (drv_en ? drv : 1'b1);

  mii_mgmt_regs #(.CLK_DIV(DIV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_sel_i(sel),
    .reg_wdata_i(wdata), .ctrl_o(ctrl), .data_o(data), .mdc_o(mdc),
    .mdio_o(mdo), .mdio_oe_o(moe), .mdio_i(line)
  );

  function automatic logic [15:0] resp(input logic [4:0] r);
    return 16'hA5C3 ^ {11'd0, r};
  endfunction

  always @(posedge mdc) begin
    if (rise_cnt < 64) begin
      seen[63-rise_cnt]    = line;
      oe_seen[63-rise_cnt] = moe;
    end
    period    = cyc - last_rise;
    last_rise = cyc;
    rise_cnt  = rise_cnt + 1;
  end

  always @(negedge mdc) begin
    if (seen[29:28] == 2'b10 && seen[27:23] == PHY_ADDR &&
        rise_cnt >= 47 && rise_cnt <= 63) begin
      drv_en = 1'b1;
      drv    = (rise_cnt == 47) ? 1'b0 : resp(seen[22:18])[63-rise_cnt];
    end else begin
      drv_en = 1'b0;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [15:0] v);
    @(negedge clk);
    we = 1'b1; sel = s; wdata = v;
    @(negedge clk);
    we = 1'b0;
  endtask

  function automatic logic [15:0] cword(input logic [4:0] p, input logic [4:0] r,
                                        input logic [1:0] op);
    return {2'b00, p, r, 2'b00, op};
  endfunction

  // issues a command and waits; returns busy cycle count
  task automatic run(input logic [15:0] cw, output int n);
    rise_cnt = 0; seen = '0; oe_seen = '0;
    wr(1'b0, cw);
    n = 0;
    while (ctrl[1:0] != 2'b00 && n < 4000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R4 reset ctrl", 64'(ctrl), 64'h0);
    chk("R8 reset mdc", 64'(mdc), 64'h0);
    chk("R7 reset oe", 64'(moe), 64'h0);
  endtask

  task automatic t_write;
    int n;
    logic [15:0] cw;
    cw = cword(5'd5, 5'd4, 2'b10);
    wr(1'b1, 16'h1DE1);
    rise_cnt = 0; seen = '0; oe_seen = '0;
    wr(1'b0, cw);
    chk("R4 busy bit set", 64'(ctrl), 64'(cw));
    wr(1'b1, 16'hBEEF); // late data write does not alter the frame
    n = 2;
    while (ctrl[1:0] != 2'b00 && n < 4000) begin n++; @(negedge clk); end
    chk("R4 write busy cycles", 64'(n), 64'(64*DIV));
    chk("R2 R3 R1 write frame", seen,
        {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd5, 5'd4, 2'b10, 16'h1DE1});
    chk("R7 write oe", oe_seen, {64{1'b1}});
    chk("R8 mdc rises", 64'(rise_cnt), 64'd64);
    chk("R8 mdc period", 64'(period), 64'(DIV));
    chk("R8 mdc idle", 64'(mdc), 64'h0);
    chk("R4 op cleared", 64'(ctrl), 64'(cw & 16'hFFFC));
  endtask

  task automatic t_read;
    int n;
    run(cword(PHY_ADDR, 5'd2, 2'b01), n);
    chk("R4 read busy cycles", 64'(n), 64'(64*DIV));
    chk("R5 read data", 64'(data), 64'(resp(5'd2)));
    chk("R2 R1 read header", seen[63:18],
        {32'hFFFF_FFFF, 2'b01, 2'b10, PHY_ADDR, 5'd2});
    chk("R7 read oe", oe_seen, {{46{1'b1}}, 18'd0});
    chk("R7 turnaround line", 64'(seen[17:16]), 64'(2'b10));
  endtask

  task automatic t_absent;
    int n;
    run(cword(5'd17, 5'd1, 2'b01), n);
    chk("R6 absent phy", 64'(data), 64'hFFFF);
  endtask

  task automatic t_both;
    int n;
    run(cword(PHY_ADDR, 5'd9, 2'b11), n);
    chk("R10 both bits opcode", 64'(seen[29:28]), 64'(2'b10));
    chk("R10 both bits data", 64'(data), 64'(resp(5'd9)));
  endtask

  task automatic t_ignore;
    int n;
    logic [15:0] cw;
    cw = cword(PHY_ADDR, 5'd3, 2'b01);
    rise_cnt = 0; seen = '0;
    wr(1'b0, cw);
    repeat (40) @(negedge clk);
    wr(1'b0, cword(5'd1, 5'd7, 2'b10));
    chk("R9 ctrl unchanged", 64'(ctrl), 64'(cw));
    n = 0;
    while (ctrl[1:0] != 2'b00 && n < 4000) begin n++; @(negedge clk); end
    repeat (100) @(negedge clk);
    chk("R9 no extra frame", 64'(rise_cnt), 64'd64);
    chk("R9 still idle", 64'(ctrl[1:0]), 64'h0);
    chk("R9 first cmd data", 64'(data), 64'(resp(5'd3)));
  endtask

  task automatic t_noop;
    rise_cnt = 0;
    wr(1'b0, 16'hC00C | cword(5'd12, 5'd6, 2'b00));
    repeat (60) @(negedge clk);
    chk("R11 readback", 64'(ctrl), 64'(16'hC00C | cword(5'd12, 5'd6, 2'b00)));
    chk("R11 no frame", 64'(rise_cnt), 64'd0);
    chk("R11 mdio idle", 64'(moe), 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_read();
    t_absent();
    t_both();
    t_ignore();
    t_noop();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule